// File: doc/BRIEF.md
# Delayed One-Shot Pulse Generator

This block produces a single output pulse whose start is delayed by a programmable number of count clocks after a start event and whose length is also programmable. It is built from two chained down-counting channels. The first (delay) channel loads the delay value on a start event and counts down. When it reaches its terminal count it raises a one-cycle event. That event is the only thing that starts the second (width) channel. The width channel loads the width value, drives the pulse output high while it counts, and raises its own one-cycle event when the pulse ends.

A start event comes either from a software strobe or from a rising edge on an asynchronous trigger input. The trigger input passes through a two-flop synchroniser on the operating clock before its edge is detected. Counting advances only in operating-clock cycles where the count-clock enable is high. A start event seen in a cycle without a count clock is remembered and takes effect on the next count clock. Clearing the channel enable returns both channels to idle and drops the output at once.

Top module: `dly_oneshot`

## Requirements
- R1: While reset is asserted, and after its release until a start event, `pulse_out`, `dly_irq` and `wid_irq` are all low.
- R2: Delay. Take the count clock on which the delay channel loads `delay_val` = D. `pulse_out` rises on the count clock D+2 count clocks later. For a software strobe sampled together with a count clock, that load happens on the same edge. The rise is then the (D+3)-th count clock, counting the strobe's edge as the first.
- R3: Width. `pulse_out` stays high for exactly W count clocks, where W = `width_val` (1 to 65535), and falls on the W-th count clock after its rise.
- R4: `dly_irq` is high for exactly one operating-clock cycle per delay count. It is set on the count clock one before `pulse_out` rises.
- R5: `wid_irq` is high for exactly one operating-clock cycle per pulse. It is set on the same edge on which `pulse_out` falls.
- R6: `ext_trig` is synchronised by two flops, and only its rising edge starts the delay channel. Its detection lags the sampling edge by two operating clocks. With the count clock always on, the rise comes on the (D+5)-th count clock, counting the edge that first samples `ext_trig` high.
- R7: The count-clock enable gates all counting. A start event in a cycle without a count clock is held and loads on the next count clock. `pulse_out` changes only on count clocks or when the channel is disabled.
- R8: `delay_val` is sampled only when the delay channel loads, and `width_val` only when the width channel loads. Writes after those loads affect only the next pulse.
- R9: A new start event during the delay count reloads the delay channel and restarts the delay. The abandoned count raises no `dly_irq`.
- R10: After a pulse ends, both channels stay idle until the next start event: no further pulse and no interrupt.
- R11: While `chan_en` is low, start events are ignored and outputs stay low. Dropping `chan_en` during a pulse drives `pulse_out` low on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operating clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count-clock enable; counters advance in cycles where it is high |
| chan_en | input | 1 | Channel enable; low holds both channels idle |
| sw_start | input | 1 | Software start strobe |
| ext_trig | input | 1 | Asynchronous external trigger; rising edge starts the delay |
| delay_val | input | 16 | Delay count D |
| width_val | input | 16 | Pulse width W |
| dly_irq | output | 1 | One-cycle event at end of the delay count |
| wid_irq | output | 1 | One-cycle event at end of the pulse |
| pulse_out | output | 1 | Delayed one-shot pulse |

## Verification
The main function is driven by a software strobe with the count clock always on, at minimum, small and large delay/width pairs. These separate the fixed +2 delay offset from off-by-one errors in either counter. The same measurement repeated through the external trigger isolates the two-flop synchroniser latency. Repeated with the count clock on in alternate cycles, it shows that counting is gated and that held start events load on the next count clock. Changing the data values mid-pulse, re-striking during the delay and disabling mid-pulse separate the correct load instants and the restart and clear paths from designs that read the values continuously or ignore retriggers.

// File: rtl/dly_oneshot_pkg.sv
package dly_oneshot_pkg;

    // How a channel decides it has finished counting.
    //   END_AFTER_ZERO : the count clock after the counter shows zero ends it
    //   END_ON_LAST    : the count clock that takes the counter to zero ends it
    typedef enum logic {
        END_AFTER_ZERO = 1'b0,
        END_ON_LAST    = 1'b1
    } end_mode_e;

    // Trigger synchroniser state.
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } sync_t;

endpackage

// File: rtl/dly_oneshot_sync.sv
module dly_oneshot_sync
    import dly_oneshot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = din;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise = st_q.sync & ~st_q.prev;

endmodule

// File: rtl/dly_oneshot_chan.sv
module dly_oneshot_chan
    import dly_oneshot_pkg::*;
#(
    parameter int        CNT_W     = 16,
    parameter end_mode_e END_MODE  = END_AFTER_ZERO,
    parameter bit        IDLE_ONES = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             trig,
    input  logic [CNT_W-1:0] load_val,
    output logic             irq,
    output logic             active
);

    localparam logic [CNT_W-1:0] IDLE_VAL = IDLE_ONES ? {CNT_W{1'b1}} : {CNT_W{1'b0}};
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             pend;
        logic             irq;
    } chan_t;

    localparam chan_t RST_ST = '{cnt: IDLE_VAL, run: 1'b0, pend: 1'b0, irq: 1'b0};

    chan_t            st_d, st_q;
    logic             finish;
    logic [CNT_W-1:0] dec;

    // Terminal condition chosen by the channel's role.
    generate
        if (END_MODE == END_ON_LAST) begin : g_end_last
            assign finish = (st_q.cnt <= ONE);
        end else begin : g_end_zero
            assign finish = (st_q.cnt == '0);
        end
    endgenerate

    assign dec = st_q.cnt - ONE;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (!en) begin
            st_d = RST_ST;
        end else if (tick) begin
            if (trig || st_q.pend) begin
                st_d.cnt  = load_val;
                st_d.run  = 1'b1;
                st_d.pend = 1'b0;
            end else if (st_q.run) begin
                if (finish) begin
                    st_d.cnt = IDLE_VAL;
                    st_d.run = 1'b0;
                    st_d.irq = 1'b1;
                end else begin
                    st_d.cnt = dec;
                end
            end
        end else if (trig) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq    = st_q.irq;
    assign active = st_q.run;

endmodule

// File: rtl/dly_oneshot.sv
module dly_oneshot
    import dly_oneshot_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             chan_en,
    input  logic             sw_start,
    input  logic             ext_trig,
    input  logic [CNT_W-1:0] delay_val,
    input  logic [CNT_W-1:0] width_val,
    output logic             dly_irq,
    output logic             wid_irq,
    output logic             pulse_out
);

    logic ext_rise;
    logic start_evt;
    logic dly_busy_unused;

    dly_oneshot_sync u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_trig),
        .rise (ext_rise)
    );

    assign start_evt = sw_start | ext_rise;

    // Delay channel: terminal event one count clock after showing zero.
    dly_oneshot_chan #(
        .CNT_W    (CNT_W),
        .END_MODE (END_AFTER_ZERO),
        .IDLE_ONES(1'b0)
    ) u_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (chan_en),
        .tick    (cnt_en),
        .trig    (start_evt),
        .load_val(delay_val),
        .irq     (dly_irq),
        .active  (dly_busy_unused)
    );

    // Width channel: started only by the delay channel's event.
    dly_oneshot_chan #(
        .CNT_W    (CNT_W),
        .END_MODE (END_ON_LAST),
        .IDLE_ONES(1'b1)
    ) u_wid (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (chan_en),
        .tick    (cnt_en),
        .trig    (dly_irq),
        .load_val(width_val),
        .irq     (wid_irq),
        .active  (pulse_out)
    );

endmodule

// File: rtl/dly_oneshot_chk.sv
module dly_oneshot_chk (
    input logic clk,
    input logic rst_n,
    input logic cnt_en,
    input logic chan_en,
    input logic dly_irq,
    input logic wid_irq,
    input logic pulse_out
);

    // R11
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (!pulse_out && !dly_irq && !wid_irq));

    // R4
    dly_irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dly_irq |=> !dly_irq);

    // R5
    wid_irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wid_irq |=> !wid_irq);

    // R5
    wid_irq_low_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wid_irq |-> !pulse_out);

    // R3
    fall_has_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pulse_out) && $past(chan_en)) |-> wid_irq);

    // R7
    pulse_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pulse_out) |-> ($past(cnt_en) || !$past(chan_en)));

endmodule

bind dly_oneshot dly_oneshot_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .chan_en  (chan_en),
    .dly_irq  (dly_irq),
    .wid_irq  (wid_irq),
    .pulse_out(pulse_out)
);

// File: tb/tb_dly_oneshot.sv
module tb_dly_oneshot;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b1;
    logic        chan_en = 1'b1;
    logic        sw_start = 1'b0;
    logic        ext_trig = 1'b0;
    logic [15:0] delay_val = 16'd0;
    logic [15:0] width_val = 16'd1;
    logic        dly_irq, wid_irq, pulse_out;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    int r_dly, r_wid, r_mi, r_si, r_mi_at, r_si_at;

    always #4 clk = ~clk;

    dly_oneshot dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .chan_en  (chan_en),
        .sw_start (sw_start),
        .ext_trig (ext_trig),
        .delay_val(delay_val),
        .width_val(width_val),
        .dly_irq  (dly_irq),
        .wid_irq  (wid_irq),
        .pulse_out(pulse_out)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Fires one start event and measures, in count clocks from the start edge:
    // rise index, width, irq counts and the tick index of each irq.
    task automatic fire(input bit use_ext, input bit slow, input int new_d, input int new_w);
        int  ticks = 0;
        int  post = 0;
        bit  ten;
        bit  risen = 1'b0;
        r_dly = -1; r_wid = -1; r_mi = 0; r_si = 0; r_mi_at = -1; r_si_at = -1;
        @(negedge clk);
        cnt_en = slow ? 1'b0 : 1'b1;
        if (use_ext) ext_trig = 1'b1; else sw_start = 1'b1;
        for (int i = 0; i < 2000; i++) begin
            ten = cnt_en;
            @(negedge clk);
            sw_start = 1'b0;
            if (ten) ticks++;
            if (dly_irq) begin r_mi++; r_mi_at = ticks; end
            if (wid_irq) begin r_si++; r_si_at = ticks; end
            if (!risen && pulse_out) begin
                risen = 1'b1;
                r_dly = ticks;
                if (new_w >= 0) width_val = 16'(new_w);
            end else if (risen && !pulse_out && r_wid < 0) begin
                r_wid = ticks - r_dly;
            end
            if (i == 1 && new_d >= 0) delay_val = 16'(new_d);
            if (r_wid >= 0) begin
                post++;
                if (post > 6) break;
            end
            if (slow) cnt_en = ~cnt_en;
        end
        ext_trig = 1'b0;
        cnt_en   = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 pulse_out in reset", int'(pulse_out), 0);
        chk("R1 dly_irq in reset", int'(dly_irq), 0);
        chk("R1 wid_irq in reset", int'(wid_irq), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 idle after reset", int'(pulse_out | dly_irq | wid_irq), 0);
    endtask

    task automatic t_soft(input int d, input int w);
        delay_val = 16'(d); width_val = 16'(w);
        fire(1'b0, 1'b0, -1, -1);
        chk("R2 soft delay", r_dly, d + 3);
        chk("R3 width", r_wid, w);
        chk("R4 dly_irq count", r_mi, 1);
        chk("R4 dly_irq tick", r_mi_at, d + 2);
        chk("R5 wid_irq count", r_si, 1);
        chk("R5 wid_irq tick", r_si_at, d + 3 + w);
    endtask

    task automatic t_ext();
        delay_val = 16'd5; width_val = 16'd2;
        fire(1'b1, 1'b0, -1, -1);
        chk("R6 ext delay", r_dly, 10);
        chk("R6 ext width", r_wid, 2);
        chk("R6 ext single dly_irq", r_mi, 1);
    endtask

    task automatic t_slow();
        delay_val = 16'd2; width_val = 16'd3;
        fire(1'b0, 1'b1, -1, -1);
        chk("R7 gated delay", r_dly, 5);
        chk("R7 gated width", r_wid, 3);
        chk("R7 gated dly_irq tick", r_mi_at, 4);
        chk("R7 gated one-cycle irqs", r_mi + r_si, 2);
    endtask

    task automatic t_update();
        delay_val = 16'd10; width_val = 16'd5;
        fire(1'b0, 1'b0, 2, 9);
        chk("R8 delay held after load", r_dly, 13);
        chk("R8 width held after load", r_wid, 5);
        fire(1'b0, 1'b0, -1, -1);
        chk("R8 new delay next pulse", r_dly, 5);
        chk("R8 new width next pulse", r_wid, 9);
    endtask

    task automatic t_restart();
        int seen = 0;
        delay_val = 16'd8; width_val = 16'd3;
        @(negedge clk);
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            seen += int'(dly_irq | pulse_out);
        end
        chk("R9 nothing before restart", seen, 0);
        fire(1'b0, 1'b0, -1, -1);
        chk("R9 restart delay", r_dly, 11);
        chk("R9 single dly_irq", r_mi, 1);
    endtask

    task automatic t_oneshot();
        int seen = 0;
        delay_val = 16'd1; width_val = 16'd2;
        fire(1'b0, 1'b0, -1, -1);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            seen += int'(dly_irq | wid_irq | pulse_out);
        end
        chk("R10 idle after pulse", seen, 0);
    endtask

    task automatic t_disable();
        int seen = 0;
        delay_val = 16'd2; width_val = 16'd20;
        @(negedge clk);
        chan_en  = 1'b0;
        sw_start = 1'b1;
        ext_trig = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            seen += int'(dly_irq | wid_irq | pulse_out);
        end
        chk("R11 starts ignored while disabled", seen, 0);
        ext_trig = 1'b0;
        repeat (4) @(negedge clk);
        chan_en  = 1'b1;
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        for (int i = 0; i < 40 && !pulse_out; i++) @(negedge clk);
        chk("R11 pulse running before disable", int'(pulse_out), 1);
        repeat (3) @(negedge clk);
        chan_en = 1'b0;
        @(negedge clk);
        chk("R11 pulse cleared on disable", int'(pulse_out), 0);
        chk("R11 no wid_irq on disable", int'(wid_irq), 0);
        chan_en = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_soft(3, 4);
        t_soft(0, 1);
        t_soft(40, 30);
        t_ext();
        t_slow();
        t_update();
        t_restart();
        t_oneshot();
        t_disable();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule